// File: doc/BRIEF.md
# Debug Command Sequencer Engine

This block sits behind a host debug serial link that delivers one byte per transfer cycle. While the CPU is halted for debugging, the engine reads a command byte, works out how many follow-on bytes that command needs, and routes each follow-on byte to the right place. Address bytes go into a 16-bit address holding register and data bytes into a 16-bit data holding register. Password bytes go into an 8-bit byte buffer. Service firmware reads these registers directly.

When the last follow-on byte of a command arrives, the engine posts the opcode's low nibble in a 4-bit command field. It then raises a one-cycle jump request to the fixed service-routine entry 0x8010 and waits for the service routine to acknowledge before it accepts another command. Two commands carry no follow-on bytes. The single-step command lets the CPU run for exactly one cycle and then re-enters debug mode. The return command sends the engine to background mode, where the CPU runs freely until a debug entry request arrives.

Top module: `dbg_cmd_seq`

## Requirements
- R1: A synchronous reset, active high, clears the address, data and byte-buffer registers, the command field, the byte counter and the jump request. It also places the engine in background mode, with dbg_mode=0 and cpu_run=1.
- R2: Opcodes 0x24 (register write) and 0x25 (memory write) take four follow-on bytes. These arrive in the order address low, address high, data low, data high. Each byte lands in its lane of the address or data register at the edge that accepts it.
- R3: At the clock edge that accepts the last follow-on byte of a command, the command field is loaded with the opcode's low nibble. jump_req is then high for exactly one cycle, with jump_addr equal to 0x8010. jump_req is never high at any other time.
- R4: Opcode 0x29 (register read) takes two follow-on bytes, address low then address high. These go into the address register, and the data register is left unchanged. The command field becomes 1001b.
- R5: Opcode 0x28 (unlock) takes 32 follow-on bytes. Each byte is copied into the byte buffer as it arrives, and the address and data registers are left unchanged. The command field becomes 1000b after the 32nd byte.
- R6: Opcode 0x26 (single step) takes no follow-on bytes. In the cycle after it is accepted, dbg_mode=0 and cpu_run=1. In the cycle after that, dbg_mode=1 and cpu_run=0. The command field does not change.
- R7: Opcode 0x27 (return) takes no follow-on bytes. It puts the engine in background mode (dbg_mode=0, cpu_run=1). While in background mode, incoming bytes are ignored. A dbg_enter pulse returns the engine to command wait with dbg_mode=1.
- R8: Any other opcode byte is ignored. No jump is raised, the command field keeps its value, and the next byte is decoded as a new opcode.
- R9: From the jump request until a svc_done pulse is sampled, every incoming byte is ignored. After svc_done, the next byte is decoded as an opcode.
- R10: Cycles with rx_valid low between the follow-on bytes do not advance the byte counter and do not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| svc_done | input | 1 | Service routine finished with the posted command |
| dbg_enter | input | 1 | Request to leave background mode and halt for debugging |
| addr_hold | output | 16 | Address holding register |
| data_hold | output | 16 | Data holding register |
| byte_buf | output | 8 | Last password byte received |
| cmd_field | output | 4 | Code of the last completed command |
| jump_req | output | 1 | One-cycle request to redirect the CPU |
| jump_addr | output | 16 | Service-routine entry address |
| dbg_mode | output | 1 | Engine is halted in debug mode |
| cpu_run | output | 1 | CPU is allowed to execute |

## Verification
The assertions assume that svc_done is raised only while a posted command is being serviced. They also assume that reset is held for at least one full clock, so that the register-change checks can exclude the cycle just after reset. The stimulus drives every input away from the active edge and raises svc_done only after the monitor has seen the jump. It also holds reset for two cycles, including one reset in the middle of a collection. Garbage bytes are presented with rx_valid low, and bytes are sent during service and in background mode, so the ignore rules are exercised only through the legal handshake.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WR_REG  = 8'h24;
    localparam logic [BYTE_W-1:0] OP_WR_MEM  = 8'h25;
    localparam logic [BYTE_W-1:0] OP_STEP    = 8'h26;
    localparam logic [BYTE_W-1:0] OP_RESUME  = 8'h27;
    localparam logic [BYTE_W-1:0] OP_UNLOCK  = 8'h28;
    localparam logic [BYTE_W-1:0] OP_RD_REG  = 8'h29;

    typedef enum logic [2:0] {
        ST_BG      = 3'd0,
        ST_WAIT    = 3'd1,
        ST_COLLECT = 3'd2,
        ST_SVC     = 3'd3,
        ST_STEP    = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        OPK_WREG   = 3'd0,
        OPK_WMEM   = 3'd1,
        OPK_STEP   = 3'd2,
        OPK_RET    = 3'd3,
        OPK_UNLOCK = 3'd4,
        OPK_RDREG  = 3'd5,
        OPK_NONE   = 3'd6
    } op_kind_e;

endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
    import dbg_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 2,
    parameter int UNLOCK_LEN = 32,
    parameter int CNT_W      = 6
) (
    input  logic [BYTE_W-1:0] op_byte,
    output op_kind_e          op_kind,
    output logic [CNT_W-1:0]  follow_cnt
);

    localparam logic [CNT_W-1:0] WRITE_LEN = CNT_W'(ADDR_BYTES + DATA_BYTES);
    localparam logic [CNT_W-1:0] READ_LEN  = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] KEY_LEN   = CNT_W'(UNLOCK_LEN);

    always_comb begin
        op_kind    = OPK_NONE;
        follow_cnt = '0;
        case (op_byte)
            OP_WR_REG: begin op_kind = OPK_WREG;   follow_cnt = WRITE_LEN; end
            OP_WR_MEM: begin op_kind = OPK_WMEM;   follow_cnt = WRITE_LEN; end
            OP_STEP:   begin op_kind = OPK_STEP;   follow_cnt = '0;        end
            OP_RESUME: begin op_kind = OPK_RET;    follow_cnt = '0;        end
            OP_UNLOCK: begin op_kind = OPK_UNLOCK; follow_cnt = KEY_LEN;   end
            OP_RD_REG: begin op_kind = OPK_RDREG;  follow_cnt = READ_LEN;  end
            default:   begin op_kind = OPK_NONE;   follow_cnt = '0;        end
        endcase
    end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [3:0]       op_nib,
    input  op_kind_e         dec_kind,
    input  logic [CNT_W-1:0] dec_need,
    input  logic             svc_done,
    input  logic             dbg_enter,
    output logic             byte_we,
    output op_kind_e         cur_kind,
    output logic [CNT_W-1:0] byte_idx,
    output logic [3:0]       cmd_code,
    output logic             jump_pulse,
    output logic             halted,
    output logic             run_en
);

    typedef struct packed {
        seq_state_e       state;
        op_kind_e         kind;
        logic [3:0]       code;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] need;
        logic [3:0]       cmd;
        logic             jump;
    } fsm_t;

    fsm_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.jump = 1'b0;
        byte_we    = 1'b0;
        case (seq_q.state)
            ST_BG: begin
                if (dbg_enter) seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    case (dec_kind)
                        OPK_NONE: seq_d.state = ST_WAIT;
                        OPK_STEP: seq_d.state = ST_STEP;
                        OPK_RET:  seq_d.state = ST_BG;
                        default: begin
                            seq_d.state = ST_COLLECT;
                            seq_d.kind  = dec_kind;
                            seq_d.code  = op_nib;
                            seq_d.need  = dec_need;
                            seq_d.cnt   = '0;
                        end
                    endcase
                end
            end
            ST_COLLECT: begin
                if (rx_valid) begin
                    byte_we = 1'b1;
                    if (seq_q.cnt == seq_q.need - CNT_W'(1)) begin
                        seq_d.state = ST_SVC;
                        seq_d.jump  = 1'b1;
                        seq_d.cmd   = seq_q.code;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_SVC: begin
                if (svc_done) seq_d.state = ST_WAIT;
            end
            ST_STEP: begin
                seq_d.state = ST_WAIT;
            end
            default: begin
                seq_d.state = ST_BG;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_BG;
            seq_q.kind  <= OPK_NONE;
            seq_q.code  <= '0;
            seq_q.cnt   <= '0;
            seq_q.need  <= '0;
            seq_q.cmd   <= '0;
            seq_q.jump  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cur_kind   = seq_q.kind;
    assign byte_idx   = seq_q.cnt;
    assign cmd_code   = seq_q.cmd;
    assign jump_pulse = seq_q.jump;
    assign run_en     = (seq_q.state == ST_BG) || (seq_q.state == ST_STEP);
    assign halted     = !run_en;

    AST_JUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        seq_q.jump |=> !seq_q.jump); // R3
    AST_JUMP_ENTERS_SVC: assert property (@(posedge clk) disable iff (rst)
        seq_q.jump |-> seq_q.state == ST_SVC); // R3
    AST_CMD_ONLY_ON_JUMP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && seq_q.cmd != $past(seq_q.cmd)) |-> seq_q.jump); // R8
    AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_STEP |=> seq_q.state == ST_WAIT); // R6
    AST_SVC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == ST_SVC && !svc_done) |=> seq_q.state == ST_SVC); // R9
    AST_BG_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == ST_BG && !dbg_enter) |=> seq_q.state == ST_BG); // R7
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == ST_COLLECT && !rx_valid) |=> $stable(seq_q.cnt)); // R10

endmodule

// File: rtl/dbg_hold_regs.sv
module dbg_hold_regs
    import dbg_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  op_kind_e          kind,
    input  logic [CNT_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BYTE_W-1:0] buf_q
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BYTE_W-1:0] bbuf;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (we) begin
            case (kind)
                OPK_WREG, OPK_WMEM: begin
                    for (int l = 0; l < ADDR_BYTES; l++)
                        if (idx == CNT_W'(l))
                            hold_d.addr[l*BYTE_W +: BYTE_W] = din;
                    for (int l = 0; l < DATA_BYTES; l++)
                        if (idx == CNT_W'(ADDR_BYTES + l))
                            hold_d.data[l*BYTE_W +: BYTE_W] = din;
                end
                OPK_RDREG: begin
                    for (int l = 0; l < ADDR_BYTES; l++)
                        if (idx == CNT_W'(l))
                            hold_d.addr[l*BYTE_W +: BYTE_W] = din;
                end
                OPK_UNLOCK: begin
                    hold_d.bbuf = din;
                end
                default: begin
                    hold_d = hold_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign addr_q = hold_q.addr;
    assign data_q = hold_q.data;
    assign buf_q  = hold_q.bbuf;

    AST_DATA_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hold_q.data != $past(hold_q.data))
        |-> $past(we && (kind == OPK_WREG || kind == OPK_WMEM))); // R4
    AST_BUF_FROM_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hold_q.bbuf != $past(hold_q.bbuf))
        |-> $past(we && kind == OPK_UNLOCK)); // R5
    AST_ADDR_NEEDS_WE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hold_q.addr != $past(hold_q.addr)) |-> $past(we)); // R2

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_seq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          UNLOCK_LEN = 32,
    parameter logic [15:0] SVC_ENTRY  = 16'h8010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              svc_done,
    input  logic              dbg_enter,
    output logic [ADDR_W-1:0] addr_hold,
    output logic [DATA_W-1:0] data_hold,
    output logic [7:0]        byte_buf,
    output logic [3:0]        cmd_field,
    output logic              jump_req,
    output logic [15:0]       jump_addr,
    output logic              dbg_mode,
    output logic              cpu_run
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int MAX_FOLLOW = (UNLOCK_LEN > ADDR_BYTES + DATA_BYTES)
                              ? UNLOCK_LEN : ADDR_BYTES + DATA_BYTES;
    localparam int CNT_W      = $clog2(MAX_FOLLOW + 1);

    op_kind_e         dec_kind;
    logic [CNT_W-1:0] dec_need;
    logic             byte_we;
    op_kind_e         cur_kind;
    logic [CNT_W-1:0] byte_idx;

    dbg_op_decode #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .UNLOCK_LEN (UNLOCK_LEN),
        .CNT_W      (CNT_W)
    ) u_decode (
        .op_byte    (rx_byte),
        .op_kind    (dec_kind),
        .follow_cnt (dec_need)
    );

    dbg_seq_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .op_nib     (rx_byte[3:0]),
        .dec_kind   (dec_kind),
        .dec_need   (dec_need),
        .svc_done   (svc_done),
        .dbg_enter  (dbg_enter),
        .byte_we    (byte_we),
        .cur_kind   (cur_kind),
        .byte_idx   (byte_idx),
        .cmd_code   (cmd_field),
        .jump_pulse (jump_req),
        .halted     (dbg_mode),
        .run_en     (cpu_run)
    );

    dbg_hold_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .we     (byte_we),
        .kind   (cur_kind),
        .idx    (byte_idx),
        .din    (rx_byte),
        .addr_q (addr_hold),
        .data_q (data_hold),
        .buf_q  (byte_buf)
    );

    assign jump_addr = SVC_ENTRY;

    AST_RUN_XOR_HALT: assert property (@(posedge clk) disable iff (rst)
        cpu_run != dbg_mode); // R6
    AST_NO_JUMP_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        jump_req |-> dbg_mode); // R3

endmodule

// File: tb/tb_dbg_cmd_seq.sv
`timescale 1ns/1ps
module tb_dbg_cmd_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        svc_done = 1'b0;
    logic        dbg_enter = 1'b0;
    logic [15:0] addr_hold, data_hold, jump_addr;
    logic [7:0]  byte_buf;
    logic [3:0]  cmd_field;
    logic        jump_req, dbg_mode, cpu_run;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0]  cmd;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  bval;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    logic [15:0] m_addr = 16'h0;
    logic [15:0] m_data = 16'h0;
    logic [7:0]  m_buf  = 8'h0;

    always #2 clk = ~clk;

    dbg_cmd_seq dut (
        .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .svc_done (svc_done), .dbg_enter (dbg_enter),
        .addr_hold (addr_hold), .data_hold (data_hold), .byte_buf (byte_buf),
        .cmd_field (cmd_field), .jump_req (jump_req), .jump_addr (jump_addr),
        .dbg_mode (dbg_mode), .cpu_run (cpu_run)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: every jump must match the next queued expectation.
    always @(negedge clk) begin
        if (!rst && jump_req && !finished) begin
            if (exp_q.size() == 0) begin
                check("R3", "unexpected jump_req", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "cmd_field", {28'h0, cmd_field}, {28'h0, e.cmd});
                check(e.req, "addr_hold", {16'h0, addr_hold}, {16'h0, e.addr});
                check(e.req, "data_hold", {16'h0, data_hold}, {16'h0, e.data});
                check(e.req, "byte_buf",  {24'h0, byte_buf},  {24'h0, e.bval});
                check("R3", "jump_addr",  {16'h0, jump_addr}, 32'h8010);
            end
        end
    end

    task automatic push(input logic [3:0] c, input string req);
        exp_t e;
        e.cmd = c; e.addr = m_addr; e.data = m_data; e.bval = m_buf; e.req = req;
        exp_q.push_back(e);
    endtask

    // Called at a negedge; the byte is taken at the next posedge.
    task automatic send(input logic [7:0] b, input int gap = 0);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h24;
        repeat (gap) @(negedge clk);
    endtask

    task automatic ack();
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic cmd_write(input logic [7:0] op, input logic [15:0] a,
                             input logic [15:0] d, input int gap, input string req);
        send(op);
        send(a[7:0], gap);
        check(req, "addr low lane after first byte", {24'h0, addr_hold[7:0]}, {24'h0, a[7:0]});
        send(a[15:8], gap);
        send(d[7:0], gap);
        m_addr = a; m_data = d;
        push(op[3:0], req);
        send(d[15:8]);
    endtask

    task automatic cmd_read(input logic [15:0] a, input string req);
        send(8'h29);
        send(a[7:0]);
        m_addr = a;
        push(4'h9, req);
        send(a[15:8]);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "jump_req",  {31'h0, jump_req}, 32'd0);
        check("R1", "cmd_field", {28'h0, cmd_field}, 32'd0);
        check("R1", "addr_hold", {16'h0, addr_hold}, 32'd0);
        check("R1", "data_hold", {16'h0, data_hold}, 32'd0);
        check("R1", "byte_buf",  {24'h0, byte_buf},  32'd0);
        check("R1", "dbg_mode",  {31'h0, dbg_mode},  32'd0);
        check("R1", "cpu_run",   {31'h0, cpu_run},   32'd1);
        rst = 1'b0;
        @(negedge clk);

        // R7 enter debug mode
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        check("R7", "dbg_mode after dbg_enter", {31'h0, dbg_mode}, 32'd1);

        // R2 register write
        cmd_write(8'h24, 16'h1234, 16'h5678, 0, "R2");
        // R9 byte during service is ignored
        send(8'h29);
        check("R9", "cmd_field during service", {28'h0, cmd_field}, 32'h4);
        ack();

        // R4 register read
        cmd_read(16'hCDAB, "R4");
        ack();

        // R2 memory write with idle gaps (R10)
        cmd_write(8'h25, 16'hBEEF, 16'h0F1E, 2, "R10");
        check("R2", "data_hold after mem write", {16'h0, data_hold}, 32'h0F1E);
        ack();

        // R8 unrecognised opcodes
        send(8'h3F);
        send(8'hA4, 1);
        check("R8", "cmd_field after bad opcode", {28'h0, cmd_field}, 32'h5);
        cmd_read(16'h2211, "R8");
        ack();

        // R5 unlock, 32 bytes
        send(8'h28);
        for (int i = 0; i < 32; i++) begin
            logic [7:0] kb;
            kb = 8'(i * 7 + 1);
            if (i == 31) begin
                m_buf = kb;
                push(4'h8, "R5");
            end
            send(kb);
            if (i == 0 || i == 15 || i == 31)
                check("R5", "byte_buf per byte", {24'h0, byte_buf}, {24'h0, kb});
        end
        check("R5", "addr_hold unchanged by unlock", {16'h0, addr_hold}, {16'h0, m_addr});
        ack();

        // R6 single step
        send(8'h26);
        check("R6", "cpu_run during step", {31'h0, cpu_run}, 32'd1);
        check("R6", "dbg_mode during step", {31'h0, dbg_mode}, 32'd0);
        @(negedge clk);
        check("R6", "cpu_run after step", {31'h0, cpu_run}, 32'd0);
        check("R6", "dbg_mode after step", {31'h0, dbg_mode}, 32'd1);
        check("R6", "cmd_field after step", {28'h0, cmd_field}, 32'h8);

        // R7 return to background, bytes ignored there
        send(8'h27);
        check("R7", "dbg_mode after return", {31'h0, dbg_mode}, 32'd0);
        check("R7", "cpu_run after return", {31'h0, cpu_run}, 32'd1);
        send(8'h29); send(8'h01); send(8'h02);
        check("R7", "addr_hold in background", {16'h0, addr_hold}, {16'h0, m_addr});
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        check("R7", "dbg_mode after re-entry", {31'h0, dbg_mode}, 32'd1);
        cmd_write(8'h24, 16'h0A0B, 16'h0C0D, 0, "R2");
        ack();

        // R1 reset mid-collection
        send(8'h24); send(8'h99);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "addr_hold after reset", {16'h0, addr_hold}, 32'd0);
        check("R1", "cmd_field after reset", {28'h0, cmd_field}, 32'd0);
        check("R1", "dbg_mode after reset", {31'h0, dbg_mode}, 32'd0);
        rst = 1'b0;
        m_addr = 16'h0; m_data = 16'h0; m_buf = 8'h0;
        @(negedge clk);
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        cmd_read(16'h3344, "R4");
        ack();
        repeat (3) @(negedge clk);

        check("R3", "pending expectations", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule